// File: doc/BRIEF.md
# Interrupt Mask and Pending Gate

This block decides whether the core sees an external interrupt request. It holds a 32-bit status word, written whole by software, and a cause view whose interrupt field spans bits 15:8. Cause bits 15:10 follow six hardware interrupt inputs on every cycle. Cause bits 9:8 are two software lines that keep the value last written to them. The request is raised when three things hold together: the global enable (status bit 0) is set, at least one line is both pending in cause and unmasked in status, and the core is not in exception level, error level or debug mode.

The gate decision is made by a small state machine with three states. `GS_QUIET` means no request. `GS_RAISED` means the request is driven. `GS_HELD` means a mode flag suppresses the request. Its transitions are *block* (any state to `GS_HELD` while a mode flag is set), *raise* (`GS_QUIET` or `GS_HELD` to `GS_RAISED` when an enabled line is pending), *drop* (`GS_RAISED` to `GS_QUIET` when nothing enabled is pending), *release* (`GS_HELD` to `GS_QUIET` when the mode flag clears and nothing is pending) and *stay*. The request output is the registered state, so it follows the gating condition one cycle later.

The status readback merges the live mode flags into their bit positions: user mode at bit 4, error level at bit 2 and exception level at bit 1. The request is evaluated again on every cycle. A status write that unmasks a line which is already pending therefore raises the request without any further event.

Top module: `irqg_gate`

## Requirements
- R1: While reset is asserted, `irq_req` is 0, the stored status word is 0 and both software cause bits are 0.
- R2: A cycle with `stat_wr_en` high stores all 32 bits of `stat_wr_data`. The stored word appears on `stat_rd` from the next cycle on.
- R3: `stat_rd` is the stored status word ORed with `mode_user` at bit 4, `mode_err` at bit 2 and `mode_exc` at bit 1.
- R4: `cause_rd[15:10]` equals `hw_irq[5:0]` in the same cycle, and `cause_rd` bits 31:16 and 7:0 read 0.
- R5: A cycle with `cause_wr_en` high loads `cause_wr_data[9:8]` into `cause_rd[9:8]`. The two bits hold while `cause_wr_en` is low, and all other written bits are ignored.
- R6: `irq_req` is 1 in the cycle after one in which status bit 0 is 1, `(status[15:8] & cause[15:8])` is nonzero and no blocking flag is set. In every other case it is 0 in that next cycle.
- R7: Any one of `mode_exc`, `mode_err` or `mode_dbg` forces `irq_req` to 0 in the next cycle.
- R8: A status write that unmasks a line already pending raises `irq_req` one cycle after the stored status changes, with no other input changing.
- R9: The software lines (cause bits 9:8) alone can raise the request once they are unmasked.
- R10: `mode_user` has no effect on `irq_req`.
- R11: With status bit 0 clear, no pending and unmasked line raises `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_data | input | 32 | Status write value |
| cause_wr_en | input | 1 | Cause write strobe (only bits 9:8 are taken) |
| cause_wr_data | input | 32 | Cause write value |
| hw_irq | input | 6 | Hardware interrupt lines, mapped to cause bits 15:10 |
| mode_user | input | 1 | Core is in user mode |
| mode_exc | input | 1 | Core is at exception level |
| mode_err | input | 1 | Core is at error level |
| mode_dbg | input | 1 | Core is in debug mode |
| irq_req | output | 1 | Registered interrupt request to the core |
| stat_rd | output | 32 | Status readback with the mode flags merged in |
| cause_rd | output | 32 | Cause readback: hardware and software lines |

## Verification
The hardest case to reach is a request caused only by a status write: a line must already be pending while it is masked, and then a single status write must unmask it while no other input moves. The stimulus first parks a hardware line high under a zero mask with the enable bit set. It confirms that the request stays low, then writes only the mask. It checks that the request is still low one cycle after the write and high one cycle after that. The same stimulus is repeated through a software line that is set by a cause write. Each mode flag is then raised on its own while the request is active.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    // Gate states: no request, request driven, request suppressed by mode
    typedef enum logic [1:0] {
        GS_QUIET  = 2'd0,
        GS_RAISED = 2'd1,
        GS_HELD   = 2'd2
    } gate_state_e;

    // Status bit positions the gate and readback depend on
    localparam int unsigned ST_IE_BIT  = 0;
    localparam int unsigned ST_EXL_BIT = 1;
    localparam int unsigned ST_ERL_BIT = 2;
    localparam int unsigned ST_UM_BIT  = 4;

endpackage

// File: rtl/irqg_status_reg.sv
module irqg_status_reg
    import irqg_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned LINE_LSB  = 8,
    parameter int unsigned NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 flag_um,
    input  logic                 flag_erl,
    input  logic                 flag_exl,
    output logic [NUM_LINES-1:0] line_mask,
    output logic                 glob_en,
    output logic [DATA_W-1:0]    rd_data
);

    localparam int unsigned LINE_MSB = LINE_LSB + NUM_LINES - 1;

    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] flag_vec;

    // Whole-word storage; no field is write-protected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (wr_en) begin
            stat_q <= wr_data;
        end
    end

    // Live mode flags placed at their status positions
    always_comb begin
        flag_vec             = '0;
        flag_vec[ST_UM_BIT]  = flag_um;
        flag_vec[ST_ERL_BIT] = flag_erl;
        flag_vec[ST_EXL_BIT] = flag_exl;
    end

    assign rd_data   = stat_q | flag_vec;
    assign line_mask = stat_q[LINE_MSB:LINE_LSB];
    assign glob_en   = stat_q[ST_IE_BIT];

endmodule

// File: rtl/irqg_cause_reg.sv
module irqg_cause_reg #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned LINE_LSB  = 8,
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned NUM_SW    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [NUM_LINES-NUM_SW-1:0]   hw_lines,
    output logic [NUM_LINES-1:0]          pending,
    output logic [DATA_W-1:0]             rd_data
);

    localparam int unsigned NUM_HW   = NUM_LINES - NUM_SW;
    localparam int unsigned SW_MSB   = LINE_LSB + NUM_SW - 1;
    localparam int unsigned LINE_MSB = LINE_LSB + NUM_LINES - 1;

    logic [NUM_SW-1:0] sw_q;
    logic              unused_cw;

    // Only the software-line bits of a cause write are kept
    assign unused_cw = ^{wr_data[DATA_W-1:SW_MSB+1], wr_data[LINE_LSB-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else if (wr_en) begin
            sw_q <= wr_data[SW_MSB:LINE_LSB];
        end
    end

    // Lower lines come from storage, upper lines straight from hardware
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        if (g < NUM_SW) begin : g_sw
            assign pending[g] = sw_q[g];
        end else begin : g_hw
            assign pending[g] = hw_lines[g-NUM_SW];
        end
    end

    always_comb begin
        rd_data                    = '0;
        rd_data[LINE_MSB:LINE_LSB] = pending;
    end

    if (NUM_HW == 0) begin : g_no_hw
        // nothing beyond software lines
    end

endmodule

// File: rtl/irqg_fsm.sv
module irqg_fsm
    import irqg_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_mask,
    input  logic [NUM_LINES-1:0] pending,
    input  logic                 glob_en,
    input  logic                 blk_exl,
    input  logic                 blk_erl,
    input  logic                 blk_dbg,
    output logic                 req
);

    gate_state_e state_q;
    gate_state_e state_d;
    logic        blocked;
    logic        live;

    assign blocked = blk_exl | blk_erl | blk_dbg;
    assign live    = glob_en & (|(line_mask & pending));

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_QUIET: begin
                if (blocked)   state_d = GS_HELD;    // block
                else if (live) state_d = GS_RAISED;  // raise
                else           state_d = GS_QUIET;   // stay
            end
            GS_RAISED: begin
                if (blocked)    state_d = GS_HELD;   // block
                else if (!live) state_d = GS_QUIET;  // drop
                else            state_d = GS_RAISED; // stay
            end
            GS_HELD: begin
                if (blocked)   state_d = GS_HELD;    // stay
                else if (live) state_d = GS_RAISED;  // raise
                else           state_d = GS_QUIET;   // release
            end
            default: state_d = GS_QUIET;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        req = 1'b0;
        unique case (state_q)
            GS_RAISED: req = 1'b1;
            GS_QUIET,
            GS_HELD:   req = 1'b0;
            default:   req = 1'b0;
        endcase
    end

endmodule

// File: rtl/irqg_gate.sv
module irqg_gate #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned LINE_LSB  = 8,
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned NUM_SW    = 2,
    localparam int unsigned NUM_HW   = NUM_LINES - NUM_SW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr_en,
    input  logic [DATA_W-1:0] stat_wr_data,
    input  logic              cause_wr_en,
    input  logic [DATA_W-1:0] cause_wr_data,
    input  logic [NUM_HW-1:0] hw_irq,
    input  logic              mode_user,
    input  logic              mode_exc,
    input  logic              mode_err,
    input  logic              mode_dbg,
    output logic              irq_req,
    output logic [DATA_W-1:0] stat_rd,
    output logic [DATA_W-1:0] cause_rd
);

    logic [NUM_LINES-1:0] line_mask;
    logic [NUM_LINES-1:0] pending;
    logic                 glob_en;

    irqg_status_reg #(
        .DATA_W    (DATA_W),
        .LINE_LSB  (LINE_LSB),
        .NUM_LINES (NUM_LINES)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (stat_wr_en),
        .wr_data   (stat_wr_data),
        .flag_um   (mode_user),
        .flag_erl  (mode_err),
        .flag_exl  (mode_exc),
        .line_mask (line_mask),
        .glob_en   (glob_en),
        .rd_data   (stat_rd)
    );

    irqg_cause_reg #(
        .DATA_W    (DATA_W),
        .LINE_LSB  (LINE_LSB),
        .NUM_LINES (NUM_LINES),
        .NUM_SW    (NUM_SW)
    ) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cause_wr_en),
        .wr_data   (cause_wr_data),
        .hw_lines  (hw_irq),
        .pending   (pending),
        .rd_data   (cause_rd)
    );

    irqg_fsm #(
        .NUM_LINES (NUM_LINES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_mask (line_mask),
        .pending   (pending),
        .glob_en   (glob_en),
        .blk_exl   (mode_exc),
        .blk_erl   (mode_err),
        .blk_dbg   (mode_dbg),
        .req       (irq_req)
    );

endmodule

// File: rtl/irqg_gate_chk.sv
module irqg_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        stat_wr_en,
    input logic [31:0] stat_wr_data,
    input logic        cause_wr_en,
    input logic [31:0] cause_wr_data,
    input logic [5:0]  hw_irq,
    input logic        mode_user,
    input logic        mode_exc,
    input logic        mode_err,
    input logic        mode_dbg,
    input logic        irq_req,
    input logic [31:0] stat_rd,
    input logic [31:0] cause_rd
);

    logic live_c;
    logic blk_c;
    assign live_c = stat_rd[0] & (|(stat_rd[15:8] & cause_rd[15:8]));
    assign blk_c  = mode_exc | mode_err | mode_dbg;

    AST_STAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_en |=> stat_rd[15:8] == $past(stat_wr_data[15:8])); // R2
    AST_USER_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_user |-> stat_rd[4]); // R3
    AST_HW_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        cause_rd[15:10] == hw_irq); // R4
    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr_en |=> cause_rd[9:8] == $past(cause_wr_data[9:8])); // R5
    AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr_en |=> $stable(cause_rd[9:8])); // R5
    AST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_c && !blk_c) |=> irq_req); // R6
    AST_NO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !live_c |=> !irq_req); // R6
    AST_MODE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        blk_c |=> !irq_req); // R7
    AST_IE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd[0] |=> !irq_req); // R11

endmodule

bind irqg_gate irqg_gate_chk u_irqg_gate_chk (.*);

// File: tb/test_irqg_gate.sv
module test_irqg_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stat_wr_en = 1'b0;
    logic [31:0] stat_wr_data = '0;
    logic        cause_wr_en = 1'b0;
    logic [31:0] cause_wr_data = '0;
    logic [5:0]  hw_irq = '0;
    logic        mode_user = 1'b0;
    logic        mode_exc = 1'b0;
    logic        mode_err = 1'b0;
    logic        mode_dbg = 1'b0;
    logic        irq_req;
    logic [31:0] stat_rd;
    logic [31:0] cause_rd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irqg_gate i_irqg_gate (
        .clk(clk), .rst_n(rst_n),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
        .cause_wr_en(cause_wr_en), .cause_wr_data(cause_wr_data),
        .hw_irq(hw_irq), .mode_user(mode_user), .mode_exc(mode_exc),
        .mode_err(mode_err), .mode_dbg(mode_dbg),
        .irq_req(irq_req), .stat_rd(stat_rd), .cause_rd(cause_rd)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m_stat = '0;
    logic [1:0]  m_sw   = '0;
    bit          m_irq  = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stat = '0; m_sw = '0; m_irq = 1'b0;
        end else begin
            logic [7:0] pend;
            pend  = {hw_irq, m_sw};
            m_irq = m_stat[0] && ((m_stat[15:8] & pend) != 0)
                    && !mode_exc && !mode_err && !mode_dbg;
            if (stat_wr_en)  m_stat = stat_wr_data;
            if (cause_wr_en) m_sw   = cause_wr_data[9:8];
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            #2;
            chk({31'd0, irq_req}, {31'd0, m_irq}, "R6 model irq");
            chk(stat_rd, m_stat | {27'd0, mode_user, 1'b0, mode_err, mode_exc, 1'b0}, "R2 R3 model status");
            chk(cause_rd, {16'd0, hw_irq, m_sw, 8'd0}, "R4 R5 model cause");
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr_stat(input logic [31:0] v);
        stat_wr_en = 1'b1; stat_wr_data = v;
        tick();
        stat_wr_en = 1'b0; stat_wr_data = '0;
    endtask

    task automatic wr_cause(input logic [31:0] v);
        cause_wr_en = 1'b1; cause_wr_data = v;
        tick();
        cause_wr_en = 1'b0; cause_wr_data = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        stat_wr_en = 1'b1; stat_wr_data = 32'hFFFF_FFFF;
        cause_wr_en = 1'b1; cause_wr_data = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk({31'd0, irq_req}, 32'd0, "R1 irq in reset");
        chk(stat_rd, 32'd0, "R1 status in reset");
        chk(cause_rd, 32'd0, "R1 cause in reset");
        stat_wr_en = 1'b0; stat_wr_data = '0;
        cause_wr_en = 1'b0; cause_wr_data = '0;
        rst_n = 1'b1;
        tick();

        // R2 whole-word status store
        wr_stat(32'h1234_00E0);
        chk(stat_rd, 32'h1234_00E0, "R2 status stored");

        // R3 flag merge
        mode_user = 1'b1; mode_err = 1'b1; mode_exc = 1'b1;
        tick();
        chk(stat_rd, 32'h1234_00F6, "R3 flags merged");
        mode_user = 1'b0; mode_err = 1'b0; mode_exc = 1'b0;
        tick();

        // R4 hardware lines
        hw_irq = 6'b101001;
        tick();
        chk(cause_rd, 32'h0000_A400, "R4 hw lines");
        hw_irq = '0;

        // R5 software lines load, hold, ignore other bits
        wr_cause(32'hFFFF_FFFF);
        chk(cause_rd, 32'h0000_0300, "R5 sw load");
        cause_wr_data = 32'h0;
        tick(2);
        chk(cause_rd, 32'h0000_0300, "R5 sw hold");
        wr_cause(32'h0000_0100);
        chk(cause_rd, 32'h0000_0100, "R5 sw partial");
        wr_cause(32'h0);

        // R11 enable bit clear blocks pending line
        hw_irq = 6'b000001;           // cause bit 10
        wr_stat(32'h0000_FF00);
        tick(2);
        chk({31'd0, irq_req}, 32'd0, "R11 ie clear");

        // R8 unmask a pending line via status write only
        wr_stat(32'h0000_0001);       // enabled, masked off
        tick(2);
        chk({31'd0, irq_req}, 32'd0, "R8 masked");
        wr_stat(32'h0000_0401);       // unmask bit 10
        chk({31'd0, irq_req}, 32'd0, "R8 one cycle after write");
        tick();
        chk({31'd0, irq_req}, 32'd1, "R8 raised");

        // R10 user mode has no effect
        mode_user = 1'b1;
        tick(2);
        chk({31'd0, irq_req}, 32'd1, "R10 user mode");
        mode_user = 1'b0;

        // R7 each blocking flag
        mode_exc = 1'b1; tick();
        chk({31'd0, irq_req}, 32'd0, "R7 exc blocks");
        mode_exc = 1'b0; tick();
        chk({31'd0, irq_req}, 32'd1, "R7 exc release");
        mode_err = 1'b1; tick();
        chk({31'd0, irq_req}, 32'd0, "R7 err blocks");
        mode_err = 1'b0; mode_dbg = 1'b1; tick();
        chk({31'd0, irq_req}, 32'd0, "R7 dbg blocks");
        mode_dbg = 1'b0; tick();
        chk({31'd0, irq_req}, 32'd1, "R7 dbg release");

        // R6 drop when the pending line falls
        hw_irq = '0; tick();
        chk({31'd0, irq_req}, 32'd0, "R6 drop");

        // R9 software line alone, pending first then unmasked
        wr_cause(32'h0000_0200);      // cause bit 9
        tick();
        chk({31'd0, irq_req}, 32'd0, "R9 masked sw");
        wr_stat(32'h0000_0201);
        tick();
        chk({31'd0, irq_req}, 32'd1, "R9 sw raises");
        wr_cause(32'h0);
        tick();
        chk({31'd0, irq_req}, 32'd0, "R9 sw cleared");

        tick(3);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule